// File: doc/BRIEF.md
# Randomized Sampling Interval Timer

This block decides when a statistical profiling unit takes its next sample. Software sets a base interval, counted in retired operations, and may switch on a random perturbation taken from an internal 16-bit pseudo-random generator. Each one-cycle retire pulse moves the countdown on by one. When the effective interval runs out, the block raises a one-cycle sample strobe and reloads for the next interval.

A build-time parameter fixes how the random amount is applied, and a read-only output reports that choice. In prepend mode the random amount lengthens the interval before counting starts. In tail mode the base interval is counted first. At its expiry the next base interval starts at once, and the sample itself waits for a random number of further retires. A second read-only output gives a 4-bit code for the smallest interval the block accepts. Any shorter programmed interval is raised to that value.

Configuration uses a single write port. Address 0 holds the base interval. Address 1 is control: bit 0 enables the timer and bit 1 enables randomization. Address 2 reloads the generator seed.

Top module: `sit_sample_timer`

## Requirements
- R1: `min_code_o` equals parameter MIN_CODE. Code meanings: 0000=256, 0010=512, 0011=768, 0100=1024, 0101=1536, 0110=2048, 0111=3072, 1000=4096; any other code is treated as 256.
- R2: A base interval written at address 0 that is below the minimum decoded from MIN_CODE is used as that minimum.
- R3: The count moves only on cycles with `retire_i` high. `sample_o` is high for exactly one cycle: the cycle after the clock edge that captured the retire completing the interval.
- R4: With randomization off (control bit 1 = 0), a strobe comes after every B retires in either mode, where B is the effective base interval.
- R5: Prepend mode (TAIL_MODE=0) with randomization on: each interval lasts B + r retires, where r is the low byte of the generator as it stands when that interval is loaded.
- R6: Tail mode (TAIL_MODE=1) with randomization on: every B retires a new base interval starts and r is taken as the generator low byte at that moment. The strobe follows r retires later, or on the expiring retire itself when r = 0.
- R7: The generator shifts left with new bit 0 = b15^b13^b12^b10. It resets to 16'hACE1 and advances once on each interval load, meaning the start after enabling and every base expiry.
- R8: A write to address 2 loads the generator from wdata[15:0]. A zero written there is stored as 16'h0001.
- R9: Clearing control bit 0 empties the count and any pending tail. No strobe occurs while disabled. Setting bit 0 again loads a fresh interval one clock after the write is captured, and retires before that load are not counted.
- R10: `tail_mode_o` equals parameter TAIL_MODE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration address: 0 base, 1 control, 2 seed |
| cfg_wdata_i | input | 16 | Configuration write data |
| retire_i | input | 1 | One-cycle pulse per eligible retired operation |
| sample_o | output | 1 | One-cycle sample strobe |
| min_code_o | output | 4 | Recommended minimum interval code |
| tail_mode_o | output | 1 | 1 when the random amount is applied as a tail |

## Verification
A configuration write lands at the edge that captures it. The interval load follows one edge later, so the bench waits two idle cycles after enabling before it issues any retire. The strobe is registered and shows in the cycle straight after the edge that captured the final retire. For that reason the bench drives `retire_i` on falling edges and, on the next falling edge, compares `sample_o` with its model's expected value for that retire count. The model tracks the generator and the pending tail itself, and it updates only on cycles that carry a retire. Every cycle with no retire must therefore show no strobe.

// File: rtl/sit_pkg.sv
package sit_pkg;

  localparam int LFSR_W = 16;
  localparam int RAND_W = 8;
  localparam int CFG_W  = 16;
  localparam logic [LFSR_W-1:0] LFSR_RST = 16'hACE1;

  typedef enum logic [1:0] {
    CFG_BASE  = 2'd0,
    CFG_CTRL  = 2'd1,
    CFG_SEED  = 2'd2,
    CFG_SPARE = 2'd3
  } cfg_addr_e;

  // Decode of the recommended minimum interval code, in retired operations.
  function automatic logic [15:0] min_interval(input logic [3:0] code);
    logic [15:0] iv;
    case (code)
      4'b0010: iv = 16'd512;
      4'b0011: iv = 16'd768;
      4'b0100: iv = 16'd1024;
      4'b0101: iv = 16'd1536;
      4'b0110: iv = 16'd2048;
      4'b0111: iv = 16'd3072;
      4'b1000: iv = 16'd4096;
      default: iv = 16'd256;
    endcase
    return iv;
  endfunction

endpackage

// File: rtl/sit_rst_sync.sv
module sit_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_no = sync_q[1];

endmodule

// File: rtl/sit_cfg_regs.sv
module sit_cfg_regs #(
  parameter int CNT_W = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cfg_we_i,
  input  logic [1:0]                  cfg_addr_i,
  input  logic [sit_pkg::CFG_W-1:0]   cfg_wdata_i,
  output logic [CNT_W-1:0]            base_o,
  output logic                        en_o,
  output logic                        rnd_en_o,
  output logic                        seed_we_o,
  output logic [sit_pkg::LFSR_W-1:0]  seed_o
);

  logic [CNT_W-1:0] base_q, base_d;
  logic             en_q, en_d;
  logic             rnd_en_q, rnd_en_d;
  logic             base_ce, ctrl_ce;

  always_comb begin
    base_ce   = cfg_we_i && (cfg_addr_i == sit_pkg::CFG_BASE);
    ctrl_ce   = cfg_we_i && (cfg_addr_i == sit_pkg::CFG_CTRL);
    seed_we_o = cfg_we_i && (cfg_addr_i == sit_pkg::CFG_SEED);
    base_d    = cfg_wdata_i[CNT_W-1:0];
    en_d      = cfg_wdata_i[0];
    rnd_en_d  = cfg_wdata_i[1];
    seed_o    = (cfg_wdata_i == '0) ? sit_pkg::LFSR_W'(1) : cfg_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
    end else if (base_ce) begin
      base_q <= base_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      rnd_en_q <= 1'b0;
    end else if (ctrl_ce) begin
      en_q     <= en_d;
      rnd_en_q <= rnd_en_d;
    end
  end

  assign base_o   = base_q;
  assign en_o     = en_q;
  assign rnd_en_o = rnd_en_q;

endmodule

// File: rtl/sit_lfsr.sv
module sit_lfsr (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       load_i,
  input  logic [sit_pkg::LFSR_W-1:0] seed_i,
  input  logic                       step_i,
  output logic [sit_pkg::LFSR_W-1:0] state_o
);

  localparam int W = sit_pkg::LFSR_W;

  logic [W-1:0] state_q, state_d;
  logic         feedback;
  logic         state_ce;

  always_comb begin
    feedback = state_q[15] ^ state_q[13] ^ state_q[12] ^ state_q[10];
    state_ce = load_i | step_i;
    if (load_i) begin
      state_d = seed_i;
    end else begin
      state_d = {state_q[W-2:0], feedback};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= sit_pkg::LFSR_RST;
    end else if (state_ce) begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/sit_interval_core.sv
module sit_interval_core #(
  parameter int CNT_W     = 16,
  parameter bit TAIL_MODE = 1'b0,
  localparam int CW       = CNT_W + 1,
  localparam int RW       = sit_pkg::RAND_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           rnd_en_i,
  input  logic [CNT_W-1:0] base_i,
  input  logic [RW-1:0]  rnd_i,
  input  logic           retire_i,
  output logic           load_o,
  output logic           running_o,
  output logic [CW-1:0]  cnt_o,
  output logic           sample_o
);

  logic          running_q, running_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_ce;
  logic          sample_q, sample_d;
  logic          start, base_exp, load;
  logic [CW-1:0] load_val;

  always_comb begin
    start    = en_i & ~running_q;
    base_exp = en_i & running_q & retire_i & (cnt_q == CW'(1));
    load     = start | base_exp;
  end

  generate
    if (TAIL_MODE == 1'b0) begin : g_prepend
      // Random amount lengthens the interval before counting begins.
      always_comb begin
        load_val = {1'b0, base_i} + (rnd_en_i ? CW'(rnd_i) : '0);
        sample_d = base_exp;
      end
    end else begin : g_tail
      // Base interval restarts at expiry; a random tail delays the strobe.
      logic [RW-1:0] tail_q, tail_d;
      logic          tail_ce;
      logic          tail_exp;
      logic          rnd_zero;

      always_comb begin
        load_val = {1'b0, base_i};
        rnd_zero = (rnd_i == '0);
        tail_exp = en_i & retire_i & (tail_q == RW'(1));
        tail_ce  = ~en_i | base_exp | retire_i;
        tail_d   = tail_q;
        if (!en_i) begin
          tail_d = '0;
        end else if (base_exp && rnd_en_i && !rnd_zero) begin
          tail_d = rnd_i;
        end else if (retire_i && (tail_q != '0)) begin
          tail_d = tail_q - RW'(1);
        end
        sample_d = (base_exp & (~rnd_en_i | rnd_zero)) | tail_exp;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          tail_q <= '0;
        end else if (tail_ce) begin
          tail_q <= tail_d;
        end
      end
    end
  endgenerate

  always_comb begin
    running_d = en_i;
    cnt_ce    = ~en_i | load | retire_i;
    cnt_d     = cnt_q;
    if (!en_i) begin
      cnt_d = '0;
    end else if (load) begin
      cnt_d = load_val;
    end else if (running_q && retire_i) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      sample_q  <= 1'b0;
    end else begin
      running_q <= running_d;
      sample_q  <= sample_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  assign load_o    = load;
  assign running_o = running_q;
  assign cnt_o     = cnt_q;
  assign sample_o  = sample_q;

endmodule

// File: rtl/sit_sample_timer.sv
module sit_sample_timer #(
  parameter int         CNT_W     = 16,
  parameter logic [3:0] MIN_CODE  = 4'b0000,
  parameter bit         TAIL_MODE = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [1:0]  cfg_addr_i,
  input  logic [15:0] cfg_wdata_i,
  input  logic        retire_i,
  output logic        sample_o,
  output logic [3:0]  min_code_o,
  output logic        tail_mode_o
);

  localparam int CW = CNT_W + 1;
  localparam logic [CNT_W-1:0] MIN_IV = CNT_W'(sit_pkg::min_interval(MIN_CODE));

  logic                       rst_sync_n;
  logic [CNT_W-1:0]           base_q;
  logic [CNT_W-1:0]           eff_base;
  logic                       en_q;
  logic                       rnd_en_q;
  logic                       seed_we;
  logic [sit_pkg::LFSR_W-1:0] seed;
  logic [sit_pkg::LFSR_W-1:0] lfsr_q;
  logic                       load;
  logic                       running_q;
  logic [CW-1:0]              cnt_q;

  sit_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  sit_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .cfg_we_i    (cfg_we_i),
    .cfg_addr_i  (cfg_addr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .base_o      (base_q),
    .en_o        (en_q),
    .rnd_en_o    (rnd_en_q),
    .seed_we_o   (seed_we),
    .seed_o      (seed)
  );

  always_comb begin
    eff_base = (base_q < MIN_IV) ? MIN_IV : base_q;
  end

  sit_lfsr u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .load_i  (seed_we),
    .seed_i  (seed),
    .step_i  (load),
    .state_o (lfsr_q)
  );

  sit_interval_core #(.CNT_W(CNT_W), .TAIL_MODE(TAIL_MODE)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .en_i      (en_q),
    .rnd_en_i  (rnd_en_q),
    .base_i    (eff_base),
    .rnd_i     (lfsr_q[sit_pkg::RAND_W-1:0]),
    .retire_i  (retire_i),
    .load_o    (load),
    .running_o (running_q),
    .cnt_o     (cnt_q),
    .sample_o  (sample_o)
  );

  assign min_code_o  = MIN_CODE;
  assign tail_mode_o = TAIL_MODE;

endmodule

// File: rtl/sit_sample_timer_chk.sv
module sit_sample_timer_chk #(
  parameter int         CNT_W    = 16,
  parameter logic [3:0] MIN_CODE = 4'b0000
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_q,
  input logic             running_q,
  input logic [CNT_W:0]   cnt_q,
  input logic [15:0]      lfsr_q,
  input logic             retire_i,
  input logic             sample_o
);

  localparam logic [CNT_W:0] MIN_IV = (CNT_W+1)'(sit_pkg::min_interval(MIN_CODE));

  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> !sample_o); // R3

  AST_STROBE_NEEDS_RETIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> $past(retire_i)); // R3

  AST_HOLD_WITHOUT_RETIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && running_q && !retire_i) |=> $stable(cnt_q)); // R3

  AST_LOAD_CLAMPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(running_q) |-> (cnt_q >= MIN_IV)); // R2

  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> !sample_o); // R9

  AST_DISABLED_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> (cnt_q == '0)); // R9

  AST_LFSR_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0); // R7

endmodule

bind sit_sample_timer sit_sample_timer_chk #(.CNT_W(CNT_W), .MIN_CODE(MIN_CODE)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_sync_n),
  .en_q      (en_q),
  .running_q (running_q),
  .cnt_q     (cnt_q),
  .lfsr_q    (lfsr_q),
  .retire_i  (retire_i),
  .sample_o  (sample_o)
);

// File: tb/sit_sample_timer_tb.sv
module sit_sample_timer_tb_top;

  localparam logic [3:0] MINC = 4'b0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        retire;
  logic        s0, s1;
  logic [3:0]  code0, code1;
  logic        tm0, tm1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // model state
  logic [15:0] m0_l, m1_l;
  int n, m0_t, m1_bt, m1_tt, B, strobes0, strobes1;
  bit ren_m;

  always #5 clk = ~clk;

  sit_sample_timer #(.MIN_CODE(MINC), .TAIL_MODE(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .retire_i(retire), .sample_o(s0),
    .min_code_o(code0), .tail_mode_o(tm0));

  sit_sample_timer #(.MIN_CODE(MINC), .TAIL_MODE(1'b1)) dut_tail_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .retire_i(retire), .sample_o(s1),
    .min_code_o(code1), .tail_mode_o(tm1));

  function automatic logic [15:0] tb_lfsr(input logic [15:0] x);
    return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
  endfunction

  function automatic int tb_min_iv(input logic [3:0] c);
    case (c)
      4'b0010: return 512;
      4'b0011: return 768;
      4'b0100: return 1024;
      4'b0101: return 1536;
      4'b0110: return 2048;
      4'b0111: return 3072;
      4'b1000: return 4096;
      default: return 256;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic start_run(input logic [15:0] seed, input int base, input bit ren);
    logic [15:0] s;
    logic [7:0]  r;
    cfg_write(2'd1, 16'h0000);
    cfg_write(2'd2, seed);
    cfg_write(2'd0, base[15:0]);
    cfg_write(2'd1, {14'd0, ren, 1'b1});
    repeat (2) @(negedge clk);
    B     = (base < tb_min_iv(MINC)) ? tb_min_iv(MINC) : base;
    ren_m = ren;
    s     = (seed == 16'h0) ? 16'h0001 : seed;
    n     = 0;
    r     = s[7:0];
    m0_l  = tb_lfsr(s);
    m0_t  = B + (ren ? int'(r) : 0);
    m1_l  = tb_lfsr(s);
    m1_bt = B;
    m1_tt = -1;
    strobes0 = 0;
    strobes1 = 0;
  endtask

  task automatic run(input int cycles, input int prob, input string t0, input string t1);
    logic [7:0] r;
    bit e0, e1, rt;
    for (int i = 0; i < cycles; i++) begin
      rt = (($urandom % 100) < prob);
      retire = rt;
      @(negedge clk);
      e0 = 1'b0; e1 = 1'b0;
      if (rt) begin
        n++;
        if (n == m0_t) begin
          e0 = 1'b1;
          r = m0_l[7:0];
          m0_l = tb_lfsr(m0_l);
          m0_t = n + B + (ren_m ? int'(r) : 0);
        end
        if (n == m1_tt) e1 = 1'b1;
        if (n == m1_bt) begin
          r = m1_l[7:0];
          m1_l = tb_lfsr(m1_l);
          m1_bt = n + B;
          if (!ren_m || r == 8'd0) e1 = 1'b1;
          else m1_tt = n + int'(r);
        end
      end
      if (s0) strobes0++;
      if (s1) strobes1++;
      chk(s0 === e0, t0, "prepend strobe", int'(s0), int'(e0));
      chk(s1 === e1, t1, "tail strobe", int'(s1), int'(e1));
    end
    retire = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed_disc;
    seed_disc = $urandom(32'd2024);
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = 2'd0; cfg_wdata = 16'h0; retire = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Reset state and static outputs (R1, R10)
    chk(s0 === 1'b0 && s1 === 1'b0, "R3", "strobe after reset", int'(s0 | s1), 0);
    chk(code0 === MINC, "R1", "min code prepend", int'(code0), int'(MINC));
    chk(code1 === MINC, "R1", "min code tail", int'(code1), int'(MINC));
    chk(tm0 === 1'b0, "R10", "mode prepend", int'(tm0), 0);
    chk(tm1 === 1'b1, "R10", "mode tail", int'(tm1), 1);
    chk(tb_min_iv(MINC) == 256, "R1", "decoded minimum", tb_min_iv(MINC), 256);

    // Plain base interval, no randomization (R4)
    start_run(16'hACE1, 300, 1'b0);
    run(2500, 70, "R4", "R4");
    chk(strobes0 > 0 && strobes1 > 0, "R3", "strobes seen", strobes0, 1);

    // Randomized, both modes (R5, R6, R7)
    start_run(16'h1234, 260, 1'b1);
    run(7000, 80, "R5", "R6");
    chk(strobes0 > 0 && strobes1 > 0, "R3", "random strobes seen", strobes1, 1);

    // Disable mid-interval: no strobes, then fresh start (R9)
    start_run(16'h0F0F, 280, 1'b1);
    run(150, 90, "R5", "R6");
    cfg_write(2'd1, 16'h0000);
    strobes0 = 0; strobes1 = 0;
    for (int i = 0; i < 400; i++) begin
      retire = (($urandom % 100) < 90);
      @(negedge clk);
      if (s0 | s1) strobes0++;
    end
    retire = 1'b0;
    chk(strobes0 == 0, "R9", "strobes while disabled", strobes0, 0);
    start_run(16'h0F0F, 280, 1'b0);
    run(1200, 90, "R9", "R9");

    // Clamp of short base interval (R2)
    start_run(16'hBEEF, 5, 1'b0);
    run(1500, 75, "R2", "R2");

    // Zero seed becomes 1 (R8)
    start_run(16'h0000, 256, 1'b1);
    run(1500, 75, "R8", "R8");

    // Seed giving zero tail first in tail mode, large addend in prepend (R6, R7)
    start_run(16'h0080, 270, 1'b1);
    run(2500, 85, "R7", "R6");

    cfg_write(2'd1, 16'h0000);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule